// File: doc/BRIEF.md
# I2C Bit-Count Serial Shift Engine

This block is the bit-level core of an I2C port that software drives one field at a time. Software loads an 8-bit shift register and picks the SDA direction. It then writes a bit count. In master mode the count write fires a burst of exactly that many SCL pulses, each with a programmable low and high phase. In slave mode the block makes no clock. It shifts one bit on each rising SCL edge from the external master until the count runs out. Data leaves and enters MSB-first. Received bits enter at the LSB on each rising SCL edge.

Both bus lines are open-drain. The block only reports when it wants a line pulled low, and a released line floats high. A held copy of the shift-register MSB drives SDA. While SCL is low that copy follows the register. While SCL is high it holds, so SDA never moves under a high clock during a burst. A bypass control makes the copy follow the register whatever SCL is doing. Software uses it to build START, STOP and repeated START without any clock. Two flags report events, each with its own enable onto the interrupt line. One flag means the count reached zero. The other means a START was seen on the bus.

Top module: `i2c_bitburst_eng`

## Requirements
- R1: After reset both line pulls are off (SCL and SDA read high), the count-done and start-seen flags are clear, irq is low and the shift register reads 0.
- R2: In master mode, writing a non-zero count N produces exactly N SCL low pulses. SCL is high before the first pulse and stays high after the last one. Writing a count of 0 produces no pulse.
- R3: In master mode each SCL low phase and each SCL high phase lasts clk_div+1 clock cycles.
- R4: With sda_drive set, bits leave MSB-first, with SDA pulled low for a 0 and released for a 1. During a burst, SDA changes only while SCL is low.
- R5: Each rising SCL edge while the count is non-zero shifts the register left by one, with the sampled SDA level entering bit 0. With sda_drive clear, data_out holds the received byte after a count of 8.
- R6: In slave mode a count write produces no SCL activity, and the count stays pending until an external master supplies rising SCL edges. One bit is shifted per edge.
- R7: done_flag sets on the edge where the count steps from 1 to 0. Any count write, including a write of 0, clears it.
- R8: start_flag sets when SDA falls while SCL stays high. SDA rising under a high SCL (STOP) does not set it. start_clr clears it.
- R9: With sda_drive and sda_bypass both set, SDA follows the register MSB with no SCL pulses. After bypass is cleared, the last level holds while SCL is high, even if the register changes. Clearing sda_drive releases SDA.
- R10: irq is high exactly when done_flag is set with done_ie set, or start_flag is set with start_ie set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1: block generates SCL bursts; 0: follows external SCL |
| sda_drive | input | 1 | 1: register MSB drives SDA; 0: SDA released and sampled |
| sda_bypass | input | 1 | With sda_drive, MSB passes to SDA regardless of SCL |
| clk_div | input | DIV_W | SCL phase length minus one, in clock cycles |
| data_wr | input | 1 | Load strobe for the shift register |
| data_in | input | DATA_W | Value loaded on data_wr |
| data_out | output | DATA_W | Current shift register contents |
| cnt_wr | input | 1 | Bit-count write strobe |
| cnt_in | input | CNT_W | Bit count written on cnt_wr |
| done_ie | input | 1 | Enables done_flag onto irq |
| start_ie | input | 1 | Enables start_flag onto irq |
| start_clr | input | 1 | Clears start_flag |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | 1: pull SCL low |
| sda_pull | output | 1 | 1: pull SDA low |
| done_flag | output | 1 | Count reached zero |
| start_flag | output | 1 | START condition seen |
| irq | output | 1 | Gated interrupt request |

## Verification
The hardest case to reach is the held SDA level after bypass is released. SDA has to stay put under a high SCL while the register changes behind it. The stimulus first forces a START through the bypass path. It then clears the bypass and loads an all-ones byte, and checks at the port that SDA is still low. A second hard case is slave mode, where the count sits unused with no clock. The bench holds SCL idle for a while after the count write, then drives the pulses itself and plays the slave's data bits on a wired-AND model of the bus.

// File: rtl/i2c_bb_pkg.sv
package i2c_bb_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } scl_phase_t;
endpackage

// File: rtl/i2c_bb_linemon.sv
// Samples the bus lines, reports rising SCL and catches START conditions.
module i2c_bb_linemon #(
   parameter bit START_DET_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic start_clr,
   output logic scl_rise,
   output logic start_flag
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise = scl_i & ~scl_q;

   generate
      if (START_DET_EN) begin : g_det
         logic start_hit;
         logic flag_q;
         assign start_hit = scl_i & scl_q & sda_q & ~sda_i;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag_q <= 1'b0;
            else if (start_hit) flag_q <= 1'b1;
            else if (start_clr) flag_q <= 1'b0;
         end
         assign start_flag = flag_q;
      end else begin : g_nodet
         logic unused_sda;
         assign unused_sda = sda_q ^ start_clr;
         assign start_flag = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_bb_shifter.sv
// Shift register and bit counter; one step per rising SCL while count > 0.
module i2c_bb_shifter #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic              scl_rise,
   input  logic              sda_i,
   output logic [DATA_W-1:0] sr,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CNT_W-1:0]  cnt_nxt,
   output logic              done_set
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic shift_en;

   assign shift_en = scl_rise && (cnt_q != '0);
   assign done_set = shift_en && (cnt_q == CNT_ONE);

   always_comb begin
      if (cnt_wr)        cnt_nxt = cnt_in;
      else if (shift_en) cnt_nxt = cnt_q - CNT_ONE;
      else               cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= '0;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_nxt;
         if (data_wr)       sr <= data_in;
         else if (shift_en) sr <= {sr[DATA_W-2:0], sda_i};
      end
   end
endmodule

// File: rtl/i2c_bb_sclgen.sv
// Master-mode SCL burst generator: low phase then high phase per bit.
module i2c_bb_sclgen
   import i2c_bb_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master,
   input  logic             launch,
   input  logic [DIV_W-1:0] clk_div,
   input  logic             cnt_left_zero,
   output logic             scl_pull
);
   scl_phase_t       ph;
   logic [DIV_W-1:0] tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         tmr <= '0;
      end else if (!master) begin
         ph  <= PH_IDLE;
         tmr <= '0;
      end else if (launch) begin
         ph  <= PH_LOW;
         tmr <= clk_div;
      end else begin
         case (ph)
            PH_LOW: begin
               if (tmr == '0) begin
                  ph  <= PH_HIGH;
                  tmr <= clk_div;
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
            PH_HIGH: begin
               if (tmr == '0) begin
                  ph  <= cnt_left_zero ? PH_IDLE : PH_LOW;
                  tmr <= clk_div;
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
            default: begin
               ph  <= PH_IDLE;
               tmr <= '0;
            end
         endcase
      end
   end

   assign scl_pull = (ph == PH_LOW);
endmodule

// File: rtl/i2c_bitburst_eng.sv
module i2c_bitburst_eng #(
   parameter int DATA_W       = 8,
   parameter int CNT_W        = 5,
   parameter int DIV_W        = 8,
   parameter bit START_DET_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_master,
   input  logic              sda_drive,
   input  logic              sda_bypass,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic              done_ie,
   input  logic              start_ie,
   input  logic              start_clr,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_pull,
   output logic              sda_pull,
   output logic              done_flag,
   output logic              start_flag,
   output logic              irq
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("i2c_bitburst_eng: DATA_W must be at least 2");
      end
      if ((2 ** CNT_W) <= DATA_W) begin : g_bad_cnt_w
         $error("i2c_bitburst_eng: CNT_W too narrow to count DATA_W bits");
      end
      if (DIV_W < 1) begin : g_bad_div_w
         $error("i2c_bitburst_eng: DIV_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] sr;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nxt;
   logic              done_set;
   logic              scl_rise;
   logic              launch;
   logic              sda_lat;
   logic              sda_eff;
   logic              done_q;

   i2c_bb_linemon #(.START_DET_EN(START_DET_EN)) u_linemon (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .start_clr  (start_clr),
      .scl_rise   (scl_rise),
      .start_flag (start_flag)
   );

   i2c_bb_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (data_wr),
      .data_in  (data_in),
      .cnt_wr   (cnt_wr),
      .cnt_in   (cnt_in),
      .scl_rise (scl_rise),
      .sda_i    (sda_i),
      .sr       (sr),
      .cnt_q    (cnt_q),
      .cnt_nxt  (cnt_nxt),
      .done_set (done_set)
   );

   assign launch = cnt_wr && (cnt_in != '0) && mode_master;

   i2c_bb_sclgen #(.DIV_W(DIV_W)) u_sclgen (
      .clk           (clk),
      .rst_n         (rst_n),
      .master        (mode_master),
      .launch        (launch),
      .clk_div       (clk_div),
      .cnt_left_zero (cnt_nxt == '0),
      .scl_pull      (scl_pull)
   );

   // Output copy of the MSB: open while SCL is low or bypass is set, held otherwise.
   assign sda_eff = (sda_bypass || !scl_i) ? sr[MSB] : sda_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sda_lat <= 1'b1;
      else        sda_lat <= sda_eff;
   end

   assign sda_pull = sda_drive & ~sda_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done_q <= 1'b0;
      else if (cnt_wr)   done_q <= 1'b0;
      else if (done_set) done_q <= 1'b1;
   end

   assign done_flag = done_q;
   assign data_out  = sr;
   assign irq       = (done_q & done_ie) | (start_flag & start_ie);
endmodule

// File: rtl/i2c_bitburst_chk.sv
module i2c_bitburst_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_master,
   input logic             sda_drive,
   input logic             sda_bypass,
   input logic             scl_i,
   input logic             sda_i,
   input logic             scl_pull,
   input logic             sda_pull,
   input logic             done_flag,
   input logic             start_flag,
   input logic [CNT_W-1:0] cnt_q
);
   // R2
   pulse_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_pull) |-> (cnt_q != '0));

   // R4
   sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i) && !sda_bypass && !$past(sda_bypass)
       && (sda_drive == $past(sda_drive))) |-> $stable(sda_pull));

   // R6
   slave_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_master && !$past(mode_master)) |-> !scl_pull);

   // R7
   done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> (cnt_q == '0));

   // R8
   start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_flag) |-> ($past(scl_i) && !$past(sda_i)));
endmodule

bind i2c_bitburst_eng i2c_bitburst_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_master (mode_master),
   .sda_drive   (sda_drive),
   .sda_bypass  (sda_bypass),
   .scl_i       (scl_i),
   .sda_i       (sda_i),
   .scl_pull    (scl_pull),
   .sda_pull    (sda_pull),
   .done_flag   (done_flag),
   .start_flag  (start_flag),
   .cnt_q       (cnt_q)
);

// File: tb/i2c_bitburst_eng_bench.sv
`timescale 1ns/1ps
module i2c_bitburst_eng_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_master = 1'b1;
   logic       sda_drive = 1'b0;
   logic       sda_bypass = 1'b0;
   logic [7:0] clk_div = 8'd3;
   logic       data_wr = 1'b0;
   logic [7:0] data_in = 8'd0;
   logic [7:0] data_out;
   logic       cnt_wr = 1'b0;
   logic [4:0] cnt_in = 5'd0;
   logic       done_ie = 1'b0;
   logic       start_ie = 1'b0;
   logic       start_clr = 1'b0;
   logic       scl_pull, sda_pull, done_flag, start_flag, irq;
   logic       tb_scl_pull = 1'b0;
   logic       tb_sda_pull = 1'b0;
   logic       scl_line, sda_line;

   assign scl_line = ~(scl_pull | tb_scl_pull);
   assign sda_line = ~(sda_pull | tb_sda_pull);

   always #10 clk = ~clk;

   i2c_bitburst_eng u_i2c_bitburst_eng (
      .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .sda_drive(sda_drive),
      .sda_bypass(sda_bypass), .clk_div(clk_div), .data_wr(data_wr), .data_in(data_in),
      .data_out(data_out), .cnt_wr(cnt_wr), .cnt_in(cnt_in), .done_ie(done_ie),
      .start_ie(start_ie), .start_clr(start_clr), .scl_i(scl_line), .sda_i(sda_line),
      .scl_pull(scl_pull), .sda_pull(sda_pull), .done_flag(done_flag),
      .start_flag(start_flag), .irq(irq)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   typedef struct { int n; int v; string tag; } exp_t;
   exp_t sbq[$];

   // Monitor: pulse counts, phase widths, SDA stability, scoreboard pops.
   int   nrise = 0, tot_rise = 0, sda_viol = 0;
   int   lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
   int   cap = 0;
   bit   in_burst = 1'b0;
   logic scl_prev = 1'b1, sda_prev = 1'b1, done_prev = 1'b0;

   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         if (scl_line && !scl_prev) begin
            cap = ((cap << 1) | int'(sda_line)) & 8'hFF;
            nrise++;
            tot_rise++;
            last_lo = lo_run;
            lo_run = 0;
         end
         if (!scl_line && scl_prev) begin
            last_hi = hi_run;
            hi_run = 0;
         end
         if (scl_line) hi_run++;
         else          lo_run++;
         if (in_burst && scl_line && scl_prev && (sda_line != sda_prev)) sda_viol++;
         if (done_flag && !done_prev) begin
            if (sbq.size() == 0) begin
               chk(1'b0, "R7", "done with no queued item", 1, 0);
            end else begin
               exp_t e;
               int   m;
               e = sbq.pop_front();
               m = (e.n >= 8) ? 255 : ((1 << e.n) - 1);
               chk(nrise == e.n, e.tag, "SCL pulse count", nrise, e.n);
               chk((cap & m) == (e.v & m), e.tag, "bits seen on SDA", cap & m, e.v & m);
            end
            nrise = 0;
            cap = 0;
         end
      end
      scl_prev  = scl_line;
      sda_prev  = sda_line;
      done_prev = done_flag;
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_data(input logic [7:0] v);
      @(negedge clk); data_in = v; data_wr = 1'b1;
      @(negedge clk); data_wr = 1'b0;
   endtask

   task automatic wr_cnt(input logic [4:0] n);
      @(negedge clk); cnt_in = n; cnt_wr = 1'b1;
      @(negedge clk); cnt_wr = 1'b0;
   endtask

   task automatic push_exp(input int n, input int v, input string tag);
      exp_t e;
      e.n = n; e.v = v; e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic wait_done(input string tag);
      int k = 0;
      while (!done_flag && k < 2000) begin @(negedge clk); k++; end
      chk(done_flag, tag, "done_flag reached", done_flag, 1);
      tick(2 * (int'(clk_div) + 2) + 2);
   endtask

   // Bench plays a slave: sets each bit while SCL is low.
   task automatic slave_drive(input logic [7:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         do @(negedge clk); while (scl_line);
         tb_sda_pull = ~v[i];
         do @(negedge clk); while (!scl_line);
      end
   endtask

   // Bench plays a master in slave mode: clocks n bits from v.
   task automatic master_clock(input logic [7:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk); tb_scl_pull = 1'b1;
         tick(1);        tb_sda_pull = ~v[i];
         tick(2);        tb_scl_pull = 1'b0;
         tick(3);
      end
   endtask

   initial begin
      int base;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      chk(scl_line == 1'b1, "R1", "SCL idle", scl_line, 1);
      chk(sda_line == 1'b1, "R1", "SDA idle", sda_line, 1);
      chk(!done_flag && !start_flag, "R1", "flags clear", {done_flag, start_flag}, 0);
      chk(irq == 1'b0, "R1", "irq low", irq, 0);
      chk(data_out == 8'h00, "R1", "register cleared", data_out, 0);

      // R2 R3 R4: master transmit of 0xA5, divider 3
      sda_drive = 1'b1;
      wr_data(8'hA5);
      push_exp(8, 8'hA5, "R2/R4");
      in_burst = 1'b1;
      wr_cnt(5'd8);
      wait_done("R2");
      in_burst = 1'b0;
      chk(last_lo == 4, "R3", "low phase cycles div=3", last_lo, 4);
      chk(last_hi == 4, "R3", "high phase cycles div=3", last_hi, 4);
      chk(sda_viol == 0, "R4", "SDA moves under high SCL", sda_viol, 0);
      chk(scl_line == 1'b1, "R2", "SCL rests high after burst", scl_line, 1);

      // R10 irq gating on done
      chk(irq == 1'b0, "R10", "irq masked with done_ie=0", irq, 0);
      @(negedge clk); done_ie = 1'b1;
      tick(1);
      chk(irq == 1'b1, "R10", "irq with done_ie=1", irq, 1);
      @(negedge clk); done_ie = 1'b0;

      // R7 count write of 0 clears done and starts nothing
      base = tot_rise;
      wr_cnt(5'd0);
      chk(done_flag == 1'b0, "R7", "count write clears done", done_flag, 0);
      tick(12);
      chk(tot_rise == base, "R2", "zero count gives no pulse", tot_rise - base, 0);
      chk(done_flag == 1'b0, "R7", "done stays clear", done_flag, 0);

      // R5 R3: master receive 0x3C, divider 1
      sda_drive = 1'b0;
      clk_div = 8'd1;
      wr_data(8'h00);
      push_exp(8, 8'h3C, "R5");
      in_burst = 1'b1;
      wr_cnt(5'd8);
      slave_drive(8'h3C, 8);
      wait_done("R5");
      in_burst = 1'b0;
      tb_sda_pull = 1'b0;
      chk(data_out == 8'h3C, "R5", "received byte", data_out, 8'h3C);
      chk(last_lo == 2, "R3", "low phase cycles div=1", last_lo, 2);
      chk(last_hi == 2, "R3", "high phase cycles div=1", last_hi, 2);

      // R2 single ACK bit (0)
      wr_data(8'h00);
      @(negedge clk); sda_drive = 1'b1;
      push_exp(1, 0, "R2");
      wr_cnt(5'd1);
      wait_done("R2");
      chk(sda_line == 1'b0, "R4", "ACK level held low", sda_line, 0);

      // R8 R9: STOP through bypass
      @(negedge clk); start_clr = 1'b1;
      @(negedge clk); start_clr = 1'b0;
      base = tot_rise;
      wr_data(8'hFF);
      @(negedge clk); sda_bypass = 1'b1;
      tick(2);
      chk(sda_line == 1'b1, "R9", "bypass raises SDA", sda_line, 1);
      chk(start_flag == 1'b0, "R8", "STOP does not set start", start_flag, 0);
      @(negedge clk); sda_bypass = 1'b0; sda_drive = 1'b0;

      // R8 R9 R10: START through bypass
      @(negedge clk); start_ie = 1'b1; sda_drive = 1'b1; sda_bypass = 1'b1;
      tick(2);
      chk(sda_line == 1'b1, "R9", "SDA high before START", sda_line, 1);
      wr_data(8'h00);
      tick(2);
      chk(sda_line == 1'b0 && scl_line == 1'b1, "R9", "SDA low under high SCL",
          {scl_line, sda_line}, 2);
      chk(start_flag == 1'b1, "R8", "START detected", start_flag, 1);
      chk(irq == 1'b1, "R10", "irq from start", irq, 1);
      @(negedge clk); sda_bypass = 1'b0;
      wr_data(8'hFF);
      tick(2);
      chk(sda_line == 1'b0, "R9", "held level after bypass off", sda_line, 0);
      @(negedge clk); start_clr = 1'b1;
      @(negedge clk); start_clr = 1'b0;
      tick(1);
      chk(start_flag == 1'b0, "R8", "start_clr clears flag", start_flag, 0);
      @(negedge clk); sda_drive = 1'b0;
      tick(2);
      chk(sda_line == 1'b1, "R9", "drive off releases SDA", sda_line, 1);
      chk(start_flag == 1'b0, "R8", "release is not START", start_flag, 0);
      chk(tot_rise == base, "R9", "no SCL during bypass", tot_rise - base, 0);
      @(negedge clk); start_ie = 1'b0;

      // R6 slave mode: count pends without clock, then 3 external edges
      @(negedge clk); mode_master = 1'b0;
      wr_data(8'h00);
      base = tot_rise;
      push_exp(3, 3'b101, "R6");
      wr_cnt(5'd3);
      tick(20);
      chk(tot_rise == base && scl_line, "R6", "no clock from slave", tot_rise - base, 0);
      chk(done_flag == 1'b0, "R6", "count still pending", done_flag, 0);
      master_clock(8'h05, 3);
      tick(3);
      tb_sda_pull = 1'b0;
      chk(done_flag == 1'b1, "R6", "done after 3 edges", done_flag, 1);
      chk(data_out == 8'h05, "R6", "slave received bits", data_out, 5);
      chk(sbq.size() == 0, "R7", "all queued items matched", sbq.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule